// File: doc/BRIEF.md
# Time-Window Link Statistics Counter

This block measures one link quantity per port and accumulates it into a 64-bit result. The quantity can be plain clock cycles, the number of cycles the link spends in one chosen power state, or the volume of payload moved on one of four payload streams. Payload volume is counted in 16-byte units. The block does not convert the count to bytes.

Software drives the block through a small 32-bit register port. The port has one control word and two result words. Writing the control word with its run bit set starts a new measurement: the result is cleared and counting begins. A measurement either runs until software clears the run bit, or stops by itself at the end of a preset window. The window lengths run from 4 µs to 4 s and are derived from the clock-frequency parameter. The two result words are separate reads that are not captured together, so a reader of a running count must read the high word again after the low word. The result wraps modulo 2^64, and no interrupt is raised.

The sequencer has three states:
- `ST_IDLE`: not counting; the result is held.
- `ST_MANUAL`: counting until software stops it.
- `ST_TIMED`: counting until the window timer expires.

Its transitions are:
- Start (a control write with the run bit set) leads from any state to `ST_TIMED` when the duration code is a preset window, and to `ST_MANUAL` otherwise.
- Stop (a control write with the run bit clear) leads from any state to `ST_IDLE`.
- Expiry leads from `ST_TIMED` to `ST_IDLE`.

Top module: `lnkstat_window_ctr`

## Requirements
- R1: After reset the control word, the low result word and the high result word all read 0.
- R2: The control word is at offset 0x10. Its fields are: report code in bits 31:24, duration code in bits 15:8, run bit in bit 0, and zeros elsewhere. The low result word is at 0x14 and the high result word at 0x18. Every other offset reads 0. Reads are combinational on the address.
- R3: A control write with bit 0 = 1 clears the 64-bit result on that clock edge. The first increment is added on the following edge.
- R4: Report code 0x00 adds 1 on every edge while a measurement is running. A control write with bit 0 = 0 stops the measurement. No increment is added on that write's edge, the count then holds, and bit 0 reads 0.
- R5: Report codes 0x01 to 0x09 count edges at which bit (code − 1) of the one-hot power-state input is 1. Bit 0 is TX L0s, bit 1 RX L0s, bit 2 L0, bit 3 L1, bit 4 L1.1, bit 5 L1.2, bit 6 configuration/recovery, bit 7 TX-and-RX L0s, and bit 8 L1 auxiliary.
- R6: Report codes 0x20 to 0x23 select payload stream (code − 0x20). Stream 0 is TX primary, 1 RX primary, 2 TX secondary, 3 RX secondary. On each edge where that stream's valid bit is 1, the stream's unit count (bits 5i+4:5i of the unit vector) is added. Other streams are ignored.
- R7: Report codes outside 0x00–0x09 and 0x20–0x23 add nothing, whatever the inputs.
- R8: Duration codes 0x01, 0x02, 0x03, 0x04, 0x05, 0x06 and 0xFF set windows of 1 ms, 10 ms, 100 ms, 1 s, 2 s, 4 s and 4 µs. A window is N = window × CLK_HZ edges, with a minimum of 1. The measurement adds exactly N increments and then stops by itself. Bit 0 reads 0 afterwards and the count holds.
- R9: Duration code 0x00 and any code not listed in R8 give manual control. Such a measurement never stops by itself.
- R10: A start written while a measurement is running restarts it: the result is cleared and the window reloads from the new duration code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| res_onehot | input | NUM_RES | One-hot link power-state vector |
| pl_vld | input | NUM_PL | Per-stream payload beat strobe |
| pl_units | input | NUM_PL*UNIT_W | Per-stream count of 16-byte units, stream i at bits UNIT_W*i upward |

## Verification
Every result is registered once. A control write or an input beat sampled on one edge shows on reg_rdata right after that edge, and a window of N edges completes on the Nth edge after the start edge. The bench drives all inputs on the falling edge. A behavioural model steps on the rising edge, and the design's read data is compared with the model 2 ns after each rising edge. The directed checks read the result words on falling edges, with the counts worked out from the number of rising edges since the start write.

// File: rtl/lnkstat_pkg.sv
package lnkstat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MANUAL = 2'd1,
        ST_TIMED  = 2'd2
    } run_state_t;

    localparam logic [7:0] OFS_CTRL = 8'h10;
    localparam logic [7:0] OFS_LO   = 8'h14;
    localparam logic [7:0] OFS_HI   = 8'h18;

    localparam logic [7:0] REP_CYCLES    = 8'h00;
    localparam logic [7:0] REP_RES_FIRST = 8'h01;
    localparam logic [7:0] REP_PL_FIRST  = 8'h20;

    localparam logic [7:0] DUR_MANUAL = 8'h00;
    localparam logic [7:0] DUR_1MS    = 8'h01;
    localparam logic [7:0] DUR_10MS   = 8'h02;
    localparam logic [7:0] DUR_100MS  = 8'h03;
    localparam logic [7:0] DUR_1S     = 8'h04;
    localparam logic [7:0] DUR_2S     = 8'h05;
    localparam logic [7:0] DUR_4S     = 8'h06;
    localparam logic [7:0] DUR_4US    = 8'hFF;

endpackage

// File: rtl/lnkstat_win_timer.sv
module lnkstat_win_timer
    import lnkstat_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] dur_code,
    input  logic       tick,
    output logic       is_timed,
    output logic       expire
);
    localparam int WIN_W = $clog2(CLK_HZ * 4 + 1) + 1;

    function automatic logic [WIN_W-1:0] win_len(input logic [7:0] c);
        longint unsigned t;
        case (c)
            DUR_1MS:   t = CLK_HZ / 1000;
            DUR_10MS:  t = CLK_HZ / 100;
            DUR_100MS: t = CLK_HZ / 10;
            DUR_1S:    t = CLK_HZ;
            DUR_2S:    t = CLK_HZ * 2;
            DUR_4S:    t = CLK_HZ * 4;
            DUR_4US:   t = (CLK_HZ * 4) / 1_000_000;
            default:   t = 0;
        endcase
        if (t == 0 && c != DUR_MANUAL && (c <= DUR_4S || c == DUR_4US))
            t = 1;
        return t[WIN_W-1:0];
    endfunction

    logic [WIN_W-1:0] remain;

    always_comb begin
        is_timed = (dur_code >= DUR_1MS && dur_code <= DUR_4S) || (dur_code == DUR_4US);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= win_len(dur_code);
        else if (tick && remain != '0)
            remain <= remain - 1'b1;
    end

    assign expire = tick && (remain == WIN_W'(1));

    assert_window_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> remain != '0);
    assert_load_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && is_timed) |=> remain != '0);

endmodule

// File: rtl/lnkstat_inc_sel.sv
module lnkstat_inc_sel
    import lnkstat_pkg::*;
#(
    parameter int NUM_RES = 9,
    parameter int NUM_PL  = 4,
    parameter int UNIT_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               rep,
    input  logic [NUM_RES-1:0]       res_onehot,
    input  logic [NUM_PL-1:0]        pl_vld,
    input  logic [NUM_PL*UNIT_W-1:0] pl_units,
    output logic [UNIT_W-1:0]        inc
);
    logic [NUM_RES-1:0] res_hit;
    logic [UNIT_W-1:0]  pl_term [NUM_PL];

    for (genvar k = 0; k < NUM_RES; k++) begin : g_res
        localparam logic [7:0] CODE = 8'(int'(REP_RES_FIRST) + k);
        assign res_hit[k] = (rep == CODE) && res_onehot[k];
    end

    for (genvar i = 0; i < NUM_PL; i++) begin : g_pl
        localparam logic [7:0] CODE = 8'(int'(REP_PL_FIRST) + i);
        assign pl_term[i] = (rep == CODE && pl_vld[i]) ? pl_units[i*UNIT_W +: UNIT_W] : '0;
    end

    always_comb begin
        inc = (rep == REP_CYCLES || |res_hit) ? UNIT_W'(1) : '0;
        for (int i = 0; i < NUM_PL; i++)
            inc = inc | pl_term[i];
    end

    assert_res_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rep >= REP_RES_FIRST && rep < 8'(int'(REP_RES_FIRST) + NUM_RES)) |-> inc <= UNIT_W'(1));

endmodule

// File: rtl/lnkstat_window_ctr.sv
module lnkstat_window_ctr
    import lnkstat_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 250_000_000,
    parameter int NUM_RES = 9,
    parameter int NUM_PL  = 4,
    parameter int UNIT_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               reg_addr,
    input  logic                     reg_we,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic [NUM_RES-1:0]       res_onehot,
    input  logic [NUM_PL-1:0]        pl_vld,
    input  logic [NUM_PL*UNIT_W-1:0] pl_units
);
    localparam int CNT_W = 64;

    run_state_t        state, state_nxt;
    logic [7:0]        rep_q, dur_q;
    logic [CNT_W-1:0]  cnt;
    logic [UNIT_W-1:0] inc;
    logic              ctl_wr, start, stop, tick, is_timed, expire;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[23:16], reg_wdata[7:1]};

    assign ctl_wr = reg_we && (reg_addr == OFS_CTRL);
    assign start  = ctl_wr && reg_wdata[0];
    assign stop   = ctl_wr && !reg_wdata[0];
    assign tick   = (state == ST_TIMED) && !ctl_wr;

    lnkstat_win_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .dur_code (reg_wdata[15:8]),
        .tick     (tick),
        .is_timed (is_timed),
        .expire   (expire)
    );

    lnkstat_inc_sel #(.NUM_RES(NUM_RES), .NUM_PL(NUM_PL), .UNIT_W(UNIT_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .rep        (rep_q),
        .res_onehot (res_onehot),
        .pl_vld     (pl_vld),
        .pl_units   (pl_units),
        .inc        (inc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        if (start)
            state_nxt = is_timed ? ST_TIMED : ST_MANUAL;
        else if (stop)
            state_nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:   state_nxt = ST_IDLE;
                ST_MANUAL: state_nxt = ST_MANUAL;
                ST_TIMED:  state_nxt = expire ? ST_IDLE : ST_TIMED;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // Control fields and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
            dur_q <= '0;
            cnt   <= '0;
        end else begin
            if (ctl_wr) begin
                rep_q <= reg_wdata[31:24];
                dur_q <= reg_wdata[15:8];
            end
            if (start)
                cnt <= '0;
            else if (state != ST_IDLE && !ctl_wr)
                cnt <= cnt + CNT_W'(inc);
        end
    end

    // Outputs
    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {rep_q, 8'h00, dur_q, 7'h00, state != ST_IDLE};
            OFS_LO:   reg_rdata = cnt[31:0];
            OFS_HI:   reg_rdata = cnt[63:32];
            default:  reg_rdata = '0;
        endcase
    end

    assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == '0);
    assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !ctl_wr) |=> cnt == $past(cnt) + CNT_W'($past(inc)));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctl_wr) |=> ($stable(cnt) && state == ST_IDLE));
    assert_self_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIMED && expire) |=> state == ST_IDLE);
    assert_manual_persists_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && !ctl_wr) |=> state == ST_MANUAL);
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> (cnt == '0 && state != ST_IDLE));

endmodule

// File: tb/lnkstat_window_ctr_bench.sv
module lnkstat_window_ctr_bench;
    localparam longint unsigned HZ = 1_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h14;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  pwr = '0;
    logic [3:0]  vld = '0;
    logic [19:0] units = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lnkstat_window_ctr #(.CLK_HZ(HZ), .NUM_RES(9), .NUM_PL(4), .UNIT_W(5)) u_lnkstat_window_ctr (
        .clk (clk), .rst_n (rst_n), .reg_addr (addr), .reg_we (we),
        .reg_wdata (wdata), .reg_rdata (rdata), .res_onehot (pwr),
        .pl_vld (vld), .pl_units (units)
    );

    // Behavioural reference model
    longint unsigned m_cnt = 0;
    longint unsigned m_rem = 0;
    logic [7:0] m_rep = 0, m_dur = 0;
    bit m_run = 0;

    function automatic longint unsigned win(input logic [7:0] d);
        case (d)
            8'h01: return HZ / 1000;
            8'h02: return HZ / 100;
            8'h03: return HZ / 10;
            8'h04: return HZ;
            8'h05: return HZ * 2;
            8'h06: return HZ * 4;
            8'hFF: return (HZ * 4) / 1_000_000;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        longint unsigned inc;
        if (!rst_n) begin
            m_cnt = 0; m_rem = 0; m_rep = 0; m_dur = 0; m_run = 0;
        end else begin
            inc = 0;
            if (m_rep == 8'h00) inc = 1;
            else if (m_rep >= 8'h01 && m_rep <= 8'h09) inc = pwr[m_rep - 1];
            else if (m_rep >= 8'h20 && m_rep <= 8'h23)
                inc = vld[m_rep - 8'h20] ? units[(m_rep - 8'h20) * 5 +: 5] : 0;
            if (we && addr == 8'h10) begin
                m_rep = wdata[31:24];
                m_dur = wdata[15:8];
                if (wdata[0]) begin
                    m_cnt = 0; m_run = 1; m_rem = win(wdata[15:8]);
                end else m_run = 0;
            end else if (m_run) begin
                m_cnt = m_cnt + inc;
                if (m_rem != 0) begin
                    if (m_rem == 1) m_run = 0;
                    m_rem = m_rem - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison with the model
    always @(posedge clk) begin
        logic [31:0] e;
        #2;
        if (rst_n && !done) begin
            case (addr)
                8'h10: e = {m_rep, 8'h00, m_dur, 7'h00, m_run};
                8'h14: e = m_cnt[31:0];
                8'h18: e = m_cnt[63:32];
                default: e = 32'h0;
            endcase
            chk("R2 per-cycle model compare", rdata, e);
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        addr = 8'h14;
    endtask

    task automatic wr_ctl(input logic [7:0] rep, input logic [7:0] dur, input logic run);
        addr = 8'h10;
        wdata = {rep, 8'h00, dur, 7'h00, run};
        we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        wdata = '0;
        addr = 8'h14;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h10, 32'h0, "R1 control after reset");
        rd(8'h14, 32'h0, "R1 low after reset");
        rd(8'h18, 32'h0, "R1 high after reset");

        // R3/R4: cycle count under manual control
        wr_ctl(8'h00, 8'h00, 1'b1);
        rd(8'h14, 32'd0, "R3 cleared on start edge");
        repeat (10) @(negedge clk);
        rd(8'h14, 32'd10, "R4 cycle count running");
        wr_ctl(8'h00, 8'h00, 1'b0);
        repeat (5) @(negedge clk);
        rd(8'h14, 32'd10, "R4 frozen after stop");
        rd(8'h10, 32'h0, "R4 run bit cleared");

        // R5: residency in L1 (bit 3)
        wr_ctl(8'h04, 8'h00, 1'b1);
        for (int i = 0; i < 8; i++) begin
            pwr = i[0] ? 9'h008 : 9'h004;
            @(negedge clk);
        end
        pwr = '0;
        wr_ctl(8'h04, 8'h00, 1'b0);
        rd(8'h14, 32'd4, "R5 L1 residency");
        rd(8'h18, 32'd0, "R5 high word");
        wr_ctl(8'h01, 8'h00, 1'b1);
        pwr = 9'h001;
        repeat (6) @(negedge clk);
        pwr = '0;
        wr_ctl(8'h01, 8'h00, 1'b0);
        rd(8'h14, 32'd6, "R5 TX L0s residency");
        wr_ctl(8'h09, 8'h00, 1'b1);
        pwr = 9'h100;
        repeat (3) @(negedge clk);
        pwr = 9'h0FF;
        repeat (3) @(negedge clk);
        pwr = '0;
        wr_ctl(8'h09, 8'h00, 1'b0);
        rd(8'h14, 32'd3, "R5 L1 aux residency");

        // R6: payload streams
        wr_ctl(8'h21, 8'h00, 1'b1);
        vld = 4'b0011;
        units = {5'd0, 5'd0, 5'd3, 5'd7};
        repeat (5) @(negedge clk);
        vld = '0;
        wr_ctl(8'h21, 8'h00, 1'b0);
        rd(8'h14, 32'd15, "R6 stream 1 units, stream 0 ignored");
        wr_ctl(8'h23, 8'h00, 1'b1);
        vld = 4'b1000;
        units = {5'd31, 15'd0};
        repeat (2) @(negedge clk);
        vld = '0;
        wr_ctl(8'h23, 8'h00, 1'b0);
        rd(8'h14, 32'd62, "R6 stream 3 units");

        // R7: unused report code
        wr_ctl(8'h15, 8'h00, 1'b1);
        pwr = 9'h1FF; vld = 4'hF; units = '1;
        repeat (10) @(negedge clk);
        pwr = '0; vld = '0; units = '0;
        wr_ctl(8'h15, 8'h00, 1'b0);
        rd(8'h14, 32'd0, "R7 unused code counts nothing");

        // R8: timed windows
        wr_ctl(8'h00, 8'hFF, 1'b1);
        repeat (20) @(negedge clk);
        rd(8'h14, 32'd4, "R8 4us window count");
        rd(8'h10, 32'h0000FF00, "R8 run bit self-cleared");
        wr_ctl(8'h00, 8'h01, 1'b1);
        repeat (1005) @(negedge clk);
        rd(8'h14, 32'd1000, "R8 1ms window count");
        wr_ctl(8'h03, 8'h02, 1'b1);
        pwr = 9'h004;
        repeat (10005) @(negedge clk);
        pwr = '0;
        rd(8'h14, 32'd10000, "R8 10ms window L0 residency");
        rd(8'h10, 32'h03000200, "R8 stopped after 10ms");

        // R9: unknown duration behaves as manual
        wr_ctl(8'h00, 8'h07, 1'b1);
        repeat (50) @(negedge clk);
        rd(8'h14, 32'd50, "R9 unknown duration still counting");
        rd(8'h10, 32'h00000701, "R9 run bit still set");
        wr_ctl(8'h00, 8'h07, 1'b0);

        // R10: restart while running
        wr_ctl(8'h00, 8'h00, 1'b1);
        repeat (7) @(negedge clk);
        rd(8'h14, 32'd7, "R10 before restart");
        wr_ctl(8'h00, 8'hFF, 1'b1);
        repeat (10) @(negedge clk);
        rd(8'h14, 32'd4, "R10 restart cleared and reloaded window");

        // R2: map and field readback
        wr_ctl(8'hAB, 8'h05, 1'b0);
        rd(8'h10, 32'hAB000500, "R2 control fields");
        rd(8'h00, 32'h0, "R2 unmapped offset 0x00");
        rd(8'h1C, 32'h0, "R2 unmapped offset 0x1C");
        rd(8'h14, 32'd4, "R2 low word held");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule